// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast clock, standing in for the VCO of a PLL, by a programmable ratio. It returns one pulse per feedback cycle to the phase detector. The clock first passes through a prescaler that divides by 8 or by 9. A main counter counts the prescaler outputs. A swallow counter keeps the prescaler at divide-by-9 for only the first few of those outputs in each cycle. With a main count M and a swallow count A, one cycle therefore lasts 9·A + 8·(M−A) = 8·M + A input clocks.

The 11-bit modulus word carries M in its upper eight bits and A in its lower three bits. Only settings with A ≤ M and M ≥ 1 produce the stated ratio. Any other setting raises an illegal flag and silences the output, so the divider never runs at a wrong ratio. While the divider is running, a new word takes effect only at the end of the cycle in progress.

Top module: `pswallow_fbdiv`

## Requirements
- R1: For a legal setting, rising pulses on pulse_o are spaced exactly 8·M + A input clocks apart, and each pulse is high for one clock.
- R2: With A = 0 the spacing is 8·M clocks.
- R3: modulus_i[10:3] is M as an unsigned number and modulus_i[2:0] is A, so the spacing equals the numeric value of a legal word.
- R4: A word with M = 0 or A > M is illegal. Once it is taken in, illegal_o reads 1 and pulse_o stays 0 for as long as that word is applied.
- R5: A word that changes during a running legal cycle does not alter that cycle's length. It governs every cycle after the next pulse.
- R6: While rst_ni is low, pulse_o and illegal_o are 0. After reset is released, the first pulse follows the (8·M + A + 1)-th rising clock edge.
- R7: While illegal_o is 1 the word is re-read on every clock. A legal word then clears illegal_o, and pulses resume at the new spacing.
- R8: Every modulus from 56 to 2047 can be set and gives that spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| modulus_i | input | 11 | Modulus word: M in [10:3], A in [2:0] |
| pulse_o | output | 1 | One-clock pulse at the end of each feedback cycle |
| illegal_o | output | 1 | Set while the applied setting cannot be divided |

## Verification
A bad prescaler count or swallow count moves the pulse spacing away from 8·M + A, and this shows on the first pulse pair after the word is applied. A main counter that misses its terminal value stretches the gap past 2047 clocks. Capturing the word in the wrong place shows up as a shortened or lengthened cycle right after a word change. A missing legality check lets pulses through while illegal_o should hold them back, which shows within one cycle of the illegal word being taken in.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int unsigned DEF_WORD_W = 11;
  localparam int unsigned DEF_PRE_DIV = 8;  // power of two; A field width follows it
endpackage

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler #(
  parameter int unsigned PRE_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic div_up_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(PRE_DIV + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] top;

  assign top    = div_up_i ? CW'(PRE_DIV) : CW'(PRE_DIV - 1);
  assign tick_o = (cnt_q == top);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pswallow_swallow_ctr.sv
module pswallow_swallow_ctr #(
  parameter int unsigned A_W = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic [A_W-1:0] load_i,
  input  logic           tick_i,
  output logic           active_o
);
  logic [A_W-1:0] left_q;

  assign active_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  left_q <= '0;
    else if (clr_i)               left_q <= load_i;
    else if (tick_i && active_o)  left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/pswallow_main_ctr.sv
module pswallow_main_ctr #(
  parameter int unsigned M_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           tick_i,
  input  logic [M_W-1:0] m_i,
  output logic           last_o
);
  logic [M_W-1:0] cnt_q;

  assign last_o = tick_i && (cnt_q == (m_i - M_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (tick_i)       cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pswallow_fbdiv.sv
module pswallow_fbdiv
  import pswallow_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned PRE_DIV = DEF_PRE_DIV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] modulus_i,
  output logic              pulse_o,
  output logic              illegal_o
);
  localparam int unsigned A_W = $clog2(PRE_DIV);
  localparam int unsigned M_W = WORD_W - A_W;

  logic [M_W-1:0] m_in;
  logic [A_W-1:0] a_in;
  logic           bad_in;

  assign m_in   = modulus_i[WORD_W-1:A_W];
  assign a_in   = modulus_i[A_W-1:0];
  assign bad_in = (m_in == '0) || (M_W'(a_in) > m_in);

  logic           load_q, illegal_q, pulse_q;
  logic [M_W-1:0] m_q;
  logic           tick, last, swallow_on, cyc_end, load;

  // word is taken only at start-up, at a cycle end, or while stalled on an illegal word
  assign cyc_end = last && !load_q && !illegal_q;
  assign load    = load_q || illegal_q || cyc_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q    <= 1'b1;
      illegal_q <= 1'b0;
      pulse_q   <= 1'b0;
      m_q       <= '0;
    end else begin
      load_q  <= 1'b0;
      pulse_q <= cyc_end;
      if (load) begin
        m_q       <= m_in;
        illegal_q <= bad_in;
      end
    end
  end

  pswallow_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (load),
    .div_up_i (swallow_on),
    .tick_o   (tick)
  );

  pswallow_swallow_ctr #(.A_W(A_W)) u_swl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (load),
    .load_i   (a_in),
    .tick_i   (tick),
    .active_o (swallow_on)
  );

  pswallow_main_ctr #(.M_W(M_W)) u_main (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .tick_i (tick),
    .m_i    (m_q),
    .last_o (last)
  );

  assign pulse_o   = pulse_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/pswallow_fbdiv_chk.sv
module pswallow_fbdiv_chk #(
  parameter int unsigned WORD_W  = 11,
  parameter int unsigned PRE_DIV = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pulse_o,
  input logic illegal_o
);
  localparam int unsigned GW = WORD_W + 2;
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (pulse_o || illegal_o) gap_q <= '0;
      else if (gap_q != GMAX)   gap_q <= gap_q + 1'b1;
      if (pulse_o)        seen_q <= 1'b1;
      else if (illegal_o) seen_q <= 1'b0;
    end
  end

  a_r1_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  a_r1_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && seen_q) |-> (gap_q >= GW'(PRE_DIV - 1)));

  a_r8_gap_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !illegal_o |-> (gap_q <= GW'(1 << WORD_W)));

  a_r4_quiet_when_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !pulse_o);

  a_r6_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> (!pulse_o && !illegal_o));
endmodule

bind pswallow_fbdiv pswallow_fbdiv_chk #(.WORD_W(WORD_W), .PRE_DIV(PRE_DIV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pulse_o   (pulse_o),
  .illegal_o (illegal_o)
);

// File: tb/sim_pswallow_fbdiv.sv
module sim_pswallow_fbdiv;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  localparam int WD_LIMIT = 190000;

  // word, expected spacing (0 = illegal)
  localparam logic [10:0] VEC_W [NVEC] = '{11'd2047, 11'd0, 11'd1024, 11'd10, 11'd56,
                                           11'd29, 11'd63, 11'd777, 11'd8, 11'd19,
                                           11'd1500, 11'd9, 11'd2040};
  localparam int VEC_P [NVEC] = '{2047, 0, 1024, 0, 56, 0, 63, 777, 8, 0, 1500, 9, 2040};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] modulus = 11'd26;
  logic        pulse, illegal;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  pswallow_fbdiv u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .modulus_i (modulus),
    .pulse_o   (pulse),
    .illegal_o (illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_pulse(input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      step();
      if (pulse) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic run_legal(input logic [10:0] w, input int exp_p, input string req);
    int n;
    modulus = w;
    wait_pulse(4200, n);
    wait_pulse(4200, n);
    check(n == exp_p, req, n, exp_p);
    check(illegal == 1'b0, "R7", int'(illegal), 0);
    step();
    check(pulse == 1'b0, "R1", int'(pulse), 0);
  endtask

  task automatic run_illegal(input logic [10:0] w);
    int n = -1;
    int pcnt = 0;
    modulus = w;
    for (int i = 1; i <= 4200; i++) begin
      step();
      if (illegal) begin
        n = i;
        break;
      end
    end
    check(n > 0, "R4", n, 1);
    for (int i = 0; i < 40; i++) begin
      step();
      if (pulse) pcnt++;
    end
    check(pcnt == 0, "R4", pcnt, 0);
    check(illegal == 1'b1, "R4", int'(illegal), 1);
  endtask

  initial begin
    int n;
    #(CLK_PERIOD*3 + 2);
    check(pulse == 1'b0, "R6", int'(pulse), 0);
    check(illegal == 1'b0, "R6", int'(illegal), 0);
    rst_ni = 1'b1;  // released between edges
    wait_pulse(200, n);
    check(n == 27, "R6", n, 27);  // M=3 A=2: 26 + 1
    step();
    check(pulse == 1'b0, "R1", int'(pulse), 0);

    for (int k = 0; k < NVEC; k++) begin
      if (VEC_P[k] == 0) run_illegal(VEC_W[k]);
      else if (VEC_P[k] >= 56) run_legal(VEC_W[k], VEC_P[k], "R8");
      else run_legal(VEC_W[k], VEC_P[k], "R3");
    end

    // R1 / R2: every legal setting for M up to 12
    for (int m = 1; m <= 12; m++) begin
      for (int a = 0; a <= 7; a++) begin
        if (a <= m) run_legal(11'(m*8 + a), m*8 + a, (a == 0) ? "R2" : "R1");
      end
    end

    // R5: change word mid-cycle
    run_legal(11'd40, 40, "R2");
    repeat (3) step();
    modulus = 11'd100;
    wait_pulse(4200, n);
    check(n == 36, "R5", n, 36);
    wait_pulse(4200, n);
    check(n == 100, "R5", n, 100);

    // R7: illegal then recovery
    run_illegal(11'd15);
    run_legal(11'd17, 17, "R7");

    // R6: reset mid-run forces outputs low at once
    run_illegal(11'd0);
    rst_ni = 1'b0;
    #1;
    check(illegal == 1'b0, "R6", int'(illegal), 0);
    check(pulse == 1'b0, "R6", int'(pulse), 0);
    modulus = 11'd9;
    #(CLK_PERIOD*2);
    rst_ni = 1'b1;
    wait_pulse(200, n);
    check(n == 10, "R6", n, 10);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule